// File: doc/BRIEF.md
# Collision Signalling with Extended-Collision Cutoff

This block sits behind the analogue front end of a coaxial-cable medium attachment unit. It receives two digital bits that the front end has already resolved. One says that the cable carries a collision-level voltage. The other says that a carrier is present. From these it produces two outputs. The first enables the receive data path toward the station. The second is a collision indication, which toggles as a square wave at one tenth of the system clock while a collision lasts and stays quiet otherwise.

A collision level is always above the carrier level, so a collision alone also enables reception. A long-period watchdog counts how many cycles a collision has lasted without a break. When that count reaches its limit, the receive path is cut while the collision indication keeps toggling. The first cycle without collision clears the watchdog and lifts the cut.

Both limits are parameters in clock cycles. The default of 20,000,000 cycles gives 200 ms at 100 MHz. A simulation can choose a short value.

Top module: `collsig_unit`

## Requirements
- R1: While reset is held, and at the first clock after it is released with both inputs low, `rx_enable_o` and `coll_tone_o` are 0.
- R2: On each clock edge that samples `carrier_i` or `coll_det_i` high, `rx_enable_o` becomes 1 at that edge. The exception is the cutoff case of R5. On an edge that samples both inputs low, it becomes 0.
- R3: Number the consecutive edges that sample `coll_det_i` high as k = 1, 2, 3, and so on. After edge k, `coll_tone_o` is 1 when (k-1) mod (2*HALF_CYCLES) < HALF_CYCLES, and 0 otherwise. The tone therefore starts high, and with HALF_CYCLES = 5 at 100 MHz it is a 10 MHz square wave with 50 ns pulses.
- R4: Any edge that samples `coll_det_i` low drives `coll_tone_o` to 0 at that edge, with no partial pulse left over.
- R5: At the edge that samples the XCOLL_LIMIT-th consecutive collision cycle, `rx_enable_o` goes to 0. It stays 0 at every further edge that samples the collision, whatever `carrier_i` is.
- R6: A single edge that samples `coll_det_i` low restarts the count from zero. At that edge `rx_enable_o` follows `carrier_i`. A fresh collision then gets the full XCOLL_LIMIT cycles again.
- R7: While the cutoff of R5 is active, `coll_tone_o` keeps following the R3 pattern without interruption.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (100 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coll_det_i | input | 1 | Collision level present on the cable |
| carrier_i | input | 1 | Carrier level present on the cable |
| rx_enable_o | output | 1 | Receive data path enable |
| coll_tone_o | output | 1 | Collision indication square wave, low when idle |

## Verification
Every output is registered exactly once behind the inputs. Each result is therefore due at the first rising edge after the stimulus is applied. The cutoff falls at the edge of the XCOLL_LIMIT-th consecutive collision sample, and the tone phase is a function of the collision run length at that same edge. The driver applies inputs on falling edges and queues the value expected after the next rising edge. The monitor pops and compares 1 ns after each rising edge, so every result is checked in exactly the cycle it is due. The stimulus covers collisions shorter than the limit, collisions beyond it, one-cycle gaps, and collisions with and without carrier.

// File: rtl/collsig_pkg.sv
`timescale 1ns/1ps
package collsig_pkg;

    // Default timing, in clock cycles of a 100 MHz system clock.
    localparam int unsigned DEF_HALF_CYCLES = 5;
    localparam int unsigned DEF_XCOLL_LIMIT = 20_000_000;

    typedef struct packed {
        logic rx_en;
        logic tone;
    } collsig_out_t;

endpackage

// File: rtl/collsig_tone.sv
`timescale 1ns/1ps
// Square-wave generator, phase-locked to the start of a collision.
module collsig_tone #(
    parameter int unsigned HALF_CYCLES = collsig_pkg::DEF_HALF_CYCLES
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic coll_i,
    output logic tone_o
);
    localparam int unsigned PERIOD = 2 * HALF_CYCLES;
    localparam int unsigned PH_W   = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF_CYCLES);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            tone;
    } tone_st_t;

    tone_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!coll_i) begin
            st_d.ph   = '0;
            st_d.tone = 1'b0;
        end else begin
            st_d.tone = (st_q.ph < PH_HALF);
            st_d.ph   = (st_q.ph == PH_LAST) ? '0 : st_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tone_o = st_q.tone;

    // R4: a cycle without collision silences the tone
    p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !coll_i |=> !tone_o);
    // R3: the first collision cycle after a quiet one starts high
    p_first_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!coll_i ##1 coll_i) |=> tone_o);
    // R3: phase stays inside one period
    p_phase_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ph <= PH_LAST);

endmodule

// File: rtl/collsig_xwatch.sv
`timescale 1ns/1ps
// Continuous-collision watchdog and receive enable.
module collsig_xwatch #(
    parameter int unsigned XCOLL_LIMIT = collsig_pkg::DEF_XCOLL_LIMIT
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic coll_i,
    input  logic carrier_i,
    output logic rx_en_o
);
    localparam int unsigned CNT_W = (XCOLL_LIMIT > 2) ? $clog2(XCOLL_LIMIT) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(XCOLL_LIMIT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             cut;
        logic             rx_en;
    } wd_st_t;

    wd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!coll_i) begin
            st_d.cnt = '0;
            st_d.cut = 1'b0;
        end else if (st_q.cnt == CNT_MAX) begin
            st_d.cut = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.cut = 1'b0;
        end
        st_d.rx_en = (carrier_i | coll_i) & ~st_d.cut;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rx_en_o = st_q.rx_en;

    // R2: no source sampled, no reception
    p_rx_needs_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(coll_i || carrier_i) |=> !rx_en_o);
    // R6: a gap in the collision hands the enable back to carrier sense
    p_gap_restores_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !coll_i |=> (rx_en_o == $past(carrier_i)));
    // R5: once cut, a continuing collision keeps reception off
    p_cut_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cut && coll_i) |=> !rx_en_o);
    // R5: run counter saturates at its limit
    p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= CNT_MAX);

endmodule

// File: rtl/collsig_unit.sv
`timescale 1ns/1ps
module collsig_unit #(
    parameter int unsigned HALF_CYCLES = collsig_pkg::DEF_HALF_CYCLES,
    parameter int unsigned XCOLL_LIMIT = collsig_pkg::DEF_XCOLL_LIMIT
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic coll_det_i,
    input  logic carrier_i,
    output logic rx_enable_o,
    output logic coll_tone_o
);
    collsig_pkg::collsig_out_t outs;

    collsig_xwatch #(.XCOLL_LIMIT(XCOLL_LIMIT)) u_xwatch (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .coll_i    (coll_det_i),
        .carrier_i (carrier_i),
        .rx_en_o   (outs.rx_en)
    );

    collsig_tone #(.HALF_CYCLES(HALF_CYCLES)) u_tone (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .coll_i (coll_det_i),
        .tone_o (outs.tone)
    );

    assign rx_enable_o = outs.rx_en;
    assign coll_tone_o = outs.tone;

endmodule

// File: tb/collsig_unit_bench.sv
`timescale 1ns/1ps
module collsig_unit_bench;
    localparam int HALF  = 5;
    localparam int LIMIT = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic coll = 1'b0;
    logic crs = 1'b0;
    logic rx_en, tone;

    always #5 clk = ~clk;

    collsig_unit #(.HALF_CYCLES(HALF), .XCOLL_LIMIT(LIMIT)) u_collsig_unit (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .coll_det_i  (coll),
        .carrier_i   (crs),
        .rx_enable_o (rx_en),
        .coll_tone_o (tone)
    );

    typedef struct packed {
        logic exp_rx;
        logic exp_tone;
        logic coll;
        logic prev_coll;
        logic cut;
    } exp_t;

    exp_t q[$];
    int compared = 0;
    int mismatched = 0;
    int run = 0;
    logic last_coll = 1'b0;
    logic done = 1'b0;

    // Driver: apply inputs on a falling edge and queue the expected outputs.
    task automatic drive(input logic c_crs, input logic c_coll, input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            @(negedge clk);
            crs  = c_crs;
            coll = c_coll;
            run  = c_coll ? run + 1 : 0;
            e.coll      = c_coll;
            e.prev_coll = last_coll;
            e.cut       = c_coll && (run >= LIMIT);
            e.exp_rx    = (c_crs || c_coll) && !e.cut;
            e.exp_tone  = c_coll && (((run - 1) % (2 * HALF)) < HALF);
            last_coll   = c_coll;
            q.push_back(e);
        end
    endtask

    // Monitor: compare 1 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                compared++;
                if (rx_en !== e.exp_rx) begin
                    mismatched++;
                    if (e.cut)
                        $display("FAIL R5 rx_enable got %b exp %b", rx_en, e.exp_rx);
                    else if (!e.coll && e.prev_coll)
                        $display("FAIL R6 rx_enable got %b exp %b", rx_en, e.exp_rx);
                    else
                        $display("FAIL R2 rx_enable got %b exp %b", rx_en, e.exp_rx);
                end
                compared++;
                if (tone !== e.exp_tone) begin
                    mismatched++;
                    if (!e.coll)
                        $display("FAIL R4 tone got %b exp %b", tone, e.exp_tone);
                    else if (e.cut)
                        $display("FAIL R7 tone got %b exp %b", tone, e.exp_tone);
                    else
                        $display("FAIL R3 tone got %b exp %b", tone, e.exp_tone);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compared++;
        if (rx_en !== 1'b0 || tone !== 1'b0) begin
            mismatched++;
            $display("FAIL R1 in reset rx=%b tone=%b exp 0 0", rx_en, tone);
        end
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        compared++;
        if (rx_en !== 1'b0 || tone !== 1'b0) begin
            mismatched++;
            $display("FAIL R1 after release rx=%b tone=%b exp 0 0", rx_en, tone);
        end

        drive(1'b0, 1'b0, 3);   // idle (R4)
        drive(1'b1, 1'b0, 5);   // carrier only (R2)
        drive(1'b1, 1'b1, 7);   // short collision (R3)
        drive(1'b1, 1'b0, 2);   // tone stops cleanly (R4)
        drive(1'b0, 1'b1, 13);  // collision without carrier (R2, R3)
        drive(1'b0, 1'b0, 2);
        drive(1'b1, 1'b1, 40);  // beyond the limit (R5, R7)
        drive(1'b1, 1'b0, 1);   // one-cycle gap (R6)
        drive(1'b1, 1'b1, 30);  // full limit granted again (R6, R5)
        drive(1'b0, 1'b0, 1);   // gap without carrier (R6)
        drive(1'b0, 1'b1, 26);  // cutoff without carrier (R5)
        drive(1'b0, 1'b1, 1);
        drive(1'b1, 1'b1, 4);   // carrier during cutoff ignored (R5)
        drive(1'b0, 1'b0, 4);
        wait (q.size() == 0);
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not finish, got hang exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule